// File: doc/BRIEF.md
# Two-by-two crossbar bus arbiter

This block sits between two processor buses and two coded-bus channels, each channel leading to one slave. Every master presents a request, the slave it wants to reach and a write flag. The arbiter's control part looks at all requests each cycle, decides who may use which channel, and drives a registered switch setting that tells a 2×2 crossbar which processor bus to steer onto each channel.

Masters that want different slaves are granted in the same cycle, so both transfers run side by side. Only when both masters name the same slave is there a contest. It is settled by a priority bit kept per channel, and the losing master waits until the channel reports completion. A grant, the switch setting and the captured write flag of a channel stay frozen until that channel pulses done. The channel then goes idle for one cycle before it can be granted again.

Top module: `xbar_arbiter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `m_gnt` and `ch_act` are 0, and both per-channel priority bits favour master 0.
- R2: Bit m of `m_slv` is the slave targeted by master m (0 = slave/channel 0, 1 = slave/channel 1). If both channels are idle and the masters request different slaves, both are granted at the same clock edge: `ch_act` becomes 2'b11 and `m_gnt` becomes 2'b11.
- R3: When both masters request the same idle channel, only one of them is granted at that edge. The other sees `m_gnt` low until a later grant.
- R4: On a conflict, the master named by the channel's priority bit wins. After every completed transfer on a channel, that channel's priority bit names the master that was not just served.
- R5: Once a channel is active, `ch_act`, `ch_sel` (0 = master 0 drives it) and `ch_wr` for that channel hold, and the owner keeps its grant, until that channel's done bit is sampled high. This holds even if the owner drops its request.
- R6: A done pulse on an active channel clears it at that edge. The channel can be granted again no earlier than the next edge.
- R7: A done pulse on an idle channel has no effect.
- R8: A master with no active request receives no grant, and a channel that no master requests stays idle.
- R9: A master holding a grant is never given the other channel, even if it retargets while granted.
- R10: `ch_wr` of a channel captures the granted master's `m_wr` bit at the grant edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | 2 | Request per master |
| m_slv | input | 2 | Target slave per master (bit m for master m) |
| m_wr | input | 2 | Write flag per master (1 = write) |
| m_gnt | output | 2 | Grant per master |
| ch_sel | output | 2 | Switch select per channel: index of the driving master |
| ch_act | output | 2 | Channel carries a granted transfer |
| ch_wr | output | 2 | Direction of the transfer on each channel |
| ch_done | input | 2 | Completion pulse per channel |

## Verification
The bench targets several corner cases. The first is two masters starting together on different slaves; a design that serialised them would show only one grant. The second is a same-slave conflict repeated across completions; a fixed-priority design would keep granting master 0 where master 1 is expected. Other cases are a requester that drops its request mid-transfer (a design that releases early clears `ch_act` before done), a done pulse on an idle channel (a careless design would corrupt the priority or state), and a granted master that retargets. A design that forgets the owner check would hand that master both channels.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NUM_M = 2;
  localparam int NUM_C = 2;
  localparam int IDX_W = $clog2(NUM_M);

  typedef logic [NUM_M-1:0] mvec_t;
  typedef logic [IDX_W-1:0] midx_t;

  // Picks the winning master from a candidate vector; prio names the
  // favoured master when both are candidates.
  function automatic midx_t pick_master(input mvec_t cand, input midx_t prio);
    if (cand == '1) return prio;
    return cand[1] ? midx_t'(1) : midx_t'(0);
  endfunction

  // Index of the master that was not just served.
  function automatic midx_t other_master(input midx_t served);
    return midx_t'(NUM_M - 1) - served;
  endfunction
endpackage

// File: rtl/xbar_cand.sv
module xbar_cand
  import xbar_pkg::*;
#(
  parameter int CH = 0
) (
  input  mvec_t m_req,
  input  mvec_t m_slv,
  input  mvec_t m_gnt,
  output mvec_t cand
);
  localparam logic CH_ID = 1'(CH);

  always_comb begin
    for (int m = 0; m < NUM_M; m++) begin
      cand[m] = m_req[m] && !m_gnt[m] && (m_slv[m] == CH_ID);
    end
  end
endmodule

// File: rtl/xbar_slot.sv
module xbar_slot
  import xbar_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mvec_t cand,
  input  mvec_t m_wr,
  input  logic  done,
  output logic  act,
  output midx_t sel,
  output logic  wr,
  output logic  take,
  output logic  rel
);
  midx_t prio;
  midx_t who;

  always_comb begin
    who  = pick_master(cand, prio);
    take = !act && (cand != '0);
    rel  = act && done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      sel  <= '0;
      wr   <= 1'b0;
      prio <= '0;
    end else if (rel) begin
      act  <= 1'b0;
      prio <= other_master(sel);
    end else if (take) begin
      act <= 1'b1;
      sel <= who;
      wr  <= m_wr[who];
    end
  end
endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter
  import xbar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] m_req,
  input  logic [1:0] m_slv,
  input  logic [1:0] m_wr,
  output logic [1:0] m_gnt,
  output logic [1:0] ch_sel,
  output logic [1:0] ch_act,
  output logic [1:0] ch_wr,
  input  logic [1:0] ch_done
);
  mvec_t cand [NUM_C];
  logic [NUM_C-1:0] take_ev;
  logic [NUM_C-1:0] rel_ev;

  for (genvar c = 0; c < NUM_C; c++) begin : g_ch
    xbar_cand #(.CH(c)) u_cand (
      .m_req(m_req),
      .m_slv(m_slv),
      .m_gnt(m_gnt),
      .cand (cand[c])
    );
    xbar_slot u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .cand (cand[c]),
      .m_wr (m_wr),
      .done (ch_done[c]),
      .act  (ch_act[c]),
      .sel  (ch_sel[c]),
      .wr   (ch_wr[c]),
      .take (take_ev[c]),
      .rel  (rel_ev[c])
    );
  end

  always_comb begin
    m_gnt = '0;
    for (int c = 0; c < NUM_C; c++) begin
      if (ch_act[c]) m_gnt[ch_sel[c]] = 1'b1;
    end
  end
endmodule

// File: rtl/xbar_arbiter_chk.sv
module xbar_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] m_req,
  input logic [1:0] m_slv,
  input logic [1:0] ch_sel,
  input logic [1:0] ch_act,
  input logic [1:0] ch_wr,
  input logic [1:0] ch_done
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_act[c] && !ch_done[c] |=> ch_act[c] && $stable(ch_sel[c]) && $stable(ch_wr[c]));
    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_act[c] && ch_done[c] |=> !ch_act[c]);
    // R8
    no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_act[c] && !((m_req[0] && m_slv[0] == c[0]) || (m_req[1] && m_slv[1] == c[0]))
      |=> !ch_act[c]);
  end

  // R9
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_act == 2'b11 && ch_sel[0] == ch_sel[1]));

  // R2
  parallel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_act == 2'b00 && m_req == 2'b11 && m_slv[0] != m_slv[1] |=> ch_act == 2'b11);
endmodule

bind xbar_arbiter xbar_arbiter_chk u_chk (.*);

// File: tb/xbar_arbiter_test.sv
module xbar_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] m_req = '0, m_slv = '0, m_wr = '0, ch_done = '0;
  logic [1:0] m_gnt, ch_sel, ch_act, ch_wr;
  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  xbar_arbiter uut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_slv(m_slv), .m_wr(m_wr),
    .m_gnt(m_gnt), .ch_sel(ch_sel), .ch_act(ch_act), .ch_wr(ch_wr),
    .ch_done(ch_done)
  );

  // {req, slv, wr, done | exp gnt, exp act, exp sel&act, exp wr&act}
  localparam int NV = 13;
  localparam logic [15:0] VEC [NV] = '{
    16'b11_10_10_00_11_11_10_10,
    16'b11_10_10_00_11_11_10_10,
    16'b11_10_10_01_10_10_10_10,
    16'b01_10_10_10_01_01_00_00,
    16'b11_00_00_01_00_00_00_00,
    16'b11_00_00_00_10_01_01_00,
    16'b11_00_00_01_00_00_00_00,
    16'b11_00_00_00_01_01_00_00,
    16'b00_00_00_10_01_01_00_00,
    16'b00_00_00_01_00_00_00_00,
    16'b00_00_00_00_00_00_00_00,
    16'b10_10_10_00_10_10_10_10,
    16'b10_00_10_00_10_10_10_10
  };

  function automatic string row_tag(input int i);
    case (i)
      0: return "R2";
      1: return "R5";
      2: return "R6";
      3: return "R6";
      4: return "R6";
      5: return "R3";
      6: return "R6";
      7: return "R4";
      8: return "R5,R7";
      9: return "R6";
      10: return "R8";
      11: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [1:0] act_v, input logic [1:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", "gnt in reset", m_gnt, 2'b00);
    check("R1", "act in reset", ch_act, 2'b00);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", "act after reset", ch_act, 2'b00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {m_req, m_slv, m_wr, ch_done} = VEC[i][15:8];
      @(posedge clk); #2;
      check(row_tag(i), "gnt", m_gnt, VEC[i][7:6]);
      check(row_tag(i), "act", ch_act, VEC[i][5:4]);
      check(row_tag(i), "sel", ch_sel & ch_act, VEC[i][3:2]);
      check(row_tag(i), "wr", ch_wr & ch_act, VEC[i][1:0]);
    end

    // R1: reset mid-transfer clears everything; priority back to master 0.
    @(negedge clk);
    m_req = 2'b00; ch_done = 2'b00; rst_n = 1'b0;
    @(posedge clk); #2;
    check("R1", "act after mid reset", ch_act, 2'b00);
    @(negedge clk) rst_n = 1'b1;
    m_req = 2'b11; m_slv = 2'b11; m_wr = 2'b01;
    @(posedge clk); #2;
    check("R1", "conflict winner after reset", m_gnt, 2'b01);
    check("R10", "wr captured ch1", ch_wr & ch_act, 2'b10);
    // R6: done then immediate regrant is one cycle later, to master 1 (R4).
    @(negedge clk) ch_done = 2'b10;
    @(posedge clk); #2;
    check("R6", "idle gap gnt", m_gnt, 2'b00);
    @(negedge clk) ch_done = 2'b00;
    @(posedge clk); #2;
    check("R4", "alternate winner", m_gnt, 2'b10);
    check("R4", "sel ch1", ch_sel & ch_act, 2'b10);

    @(negedge clk);
    finish_run();
  end
endmodule